// File: doc/BRIEF.md
# Eight-Character Display Line Buffer

This block holds one line of eight characters for a small text display and exposes it as a tiny memory-mapped region. A bus master reads and writes the line with accesses of 1, 2, 4 or 8 bytes at any byte offset. Multi-byte accesses wrap around the end of the eight-byte store. Data lane 0 is always the least significant byte of the bus word.

Every accepted write repaints the whole line on a byte-stream output with a valid/ready handshake. The repaint is a carriage return followed by all eight stored characters, starting at index 0. The first time the display link comes up after reset, a single blank character goes out to wake the display.

The stored bytes change as soon as the write is accepted. A write that lands while a repaint is still draining queues exactly one more repaint. Any number of such writes fold into that one queued repaint, and repaints are never mixed together on the stream.

Top module: `char_line_buffer`

## Requirements
- R1: After reset all eight stored bytes are 0x00, outValid is low, and no byte is sent until a write or a link rise occurs.
- R2: On a write of S bytes at offset A, bus lane k (bits 8k+7..8k) for k < S is stored at index (A + k) mod 8. Lanes k >= S store nothing.
- R3: A read of S bytes at offset A returns index (A + k) mod 8 in lane k for k < S. All lanes at or above S read as zero, and busRdData is zero when no legal read is presented.
- R4: Only busSize values 1, 2, 4 and 8 are legal. Any other value changes no stored byte, starts no repaint and reads as all zeros.
- R5: After each legal write the stream carries 0x0D, then stored bytes 0 through 7 in index order, nine bytes in total.
- R6: A stored byte of 0x00 is sent as 0x20, so every repaint is nine bytes wide and outData never carries 0x00 while outValid is high.
- R7: The first 0-to-1 transition of linkUp after reset sends exactly one 0x20. Later rises send nothing. The blank never splits a repaint.
- R8: A write accepted during a repaint updates the store at once and causes exactly one further complete repaint after the current one, no matter how many such writes arrive.
- R9: While outValid is high and outReady is low, outValid stays high and outData does not change. Every stream sequence begins with 0x0D or 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Access strobe for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Byte offset of lane 0 |
| busSize | input | 4 | Access size in bytes (1, 2, 4 or 8 are legal) |
| busWrData | input | 64 | Write data, lane 0 in bits 7..0 |
| busRdData | output | 64 | Read data, combinational, lane 0 in bits 7..0 |
| linkUp | input | 1 | Display link is open |
| outValid | output | 1 | Stream byte is offered |
| outData | output | 8 | Stream byte |
| outReady | input | 1 | Display accepts the offered byte |

## Verification
On every cycle the assertions check the following:
- the stream holds its byte while it is stalled;
- no 0x00 byte is ever offered;
- every sequence opens with a carriage return or a blank;
- reads with an illegal size, and lanes above the access size, return zero.

Only the bench's scenarios can show the byte order of a whole repaint, the wrapped lane mapping of writes and reads, and the one-time nature of the link blank. They also show that an illegal write really starts nothing, and that writes during a stalled repaint add exactly one extra repaint and no more.

// File: rtl/clb_pkg.sv
`timescale 1ns/1ps
package clb_pkg;
  localparam logic [7:0] CR_CODE    = 8'h0D;
  localparam logic [7:0] SPACE_CODE = 8'h20;

  // Which byte the output register loads on a stream beat.
  typedef enum logic [1:0] {
    SEL_CR    = 2'd0,
    SEL_SPACE = 2'd1,
    SEL_CHAR  = 2'd2
  } outSel_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic    loadOut;
    outSel_e sel;
  } strobes_t;
endpackage

// File: rtl/clb_datapath.sv
`timescale 1ns/1ps
module clb_datapath
  import clb_pkg::*;
#(
  parameter  int CHARS  = 8,
  localparam int IDX_W  = $clog2(CHARS),
  localparam int SIZE_W = $clog2(CHARS) + 1,
  localparam int DATA_W = CHARS * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [IDX_W-1:0]  busAddr,
  input  logic [SIZE_W-1:0] busSize,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  strobes_t          strobes,
  input  logic [IDX_W-1:0]  charIdx,
  output logic              wrFire,
  output logic [7:0]        outData
);
  logic       sizeOk;
  logic       rdFire;
  logic [7:0] charMem [CHARS];
  logic [7:0] wrLane  [CHARS];
  logic [7:0] picked;

  // A legal size is a power of two between 1 and CHARS.
  assign sizeOk = (busSize != '0)
               && ((busSize & (busSize - 1'b1)) == '0)
               && (busSize <= SIZE_W'(CHARS));
  assign wrFire = busValid && busWrite && sizeOk;
  assign rdFire = busValid && !busWrite && sizeOk;

  for (genvar k = 0; k < CHARS; k++) begin : g_lane
    logic [IDX_W-1:0] srcIdx;
    assign wrLane[k] = busWrData[8*k +: 8];
    assign srcIdx    = busAddr + IDX_W'(k);
    assign busRdData[8*k +: 8] =
      (rdFire && (SIZE_W'(k) < busSize)) ? charMem[srcIdx] : 8'h00;
  end

  // Each cell works out which lane feeds it; the index wraps modulo CHARS.
  for (genvar j = 0; j < CHARS; j++) begin : g_cell
    logic [IDX_W-1:0] laneIdx;
    logic [7:0]       cellQ;
    assign laneIdx = IDX_W'(j) - busAddr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cellQ <= 8'h00;
      end else if (wrFire && (SIZE_W'(laneIdx) < busSize)) begin
        cellQ <= wrLane[laneIdx];
      end
    end
    assign charMem[j] = cellQ;
  end

  assign picked = charMem[charIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outData <= 8'h00;
    end else if (strobes.loadOut) begin
      case (strobes.sel)
        SEL_CR:    outData <= CR_CODE;
        SEL_SPACE: outData <= SPACE_CODE;
        default:   outData <= (picked == 8'h00) ? SPACE_CODE : picked;
      endcase
    end
  end
endmodule

// File: rtl/clb_control.sv
`timescale 1ns/1ps
module clb_control
  import clb_pkg::*;
#(
  parameter  int CHARS  = 8,
  localparam int IDX_W  = $clog2(CHARS),
  localparam int BEAT_W = $clog2(CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrFire,
  input  logic             linkUp,
  input  logic             outReady,
  output logic             outValid,
  output strobes_t         strobes,
  output logic [IDX_W-1:0] charIdx
);
  logic              active;
  logic [BEAT_W-1:0] beat;
  logic              refreshPend;
  logic              greetPend;
  logic              greetDone;
  logic              linkPrev;
  logic              advance;
  logic              linkRise;

  assign advance  = !outValid || outReady;
  assign linkRise = linkUp && !linkPrev;
  assign charIdx  = IDX_W'(beat - BEAT_W'(1));

  // A running repaint goes first, then the one-time blank, then a queued repaint.
  always_comb begin
    strobes = '{loadOut: 1'b0, sel: SEL_CR};
    if (advance) begin
      if (active) begin
        strobes = '{loadOut: 1'b1, sel: SEL_CHAR};
      end else if (greetPend) begin
        strobes = '{loadOut: 1'b1, sel: SEL_SPACE};
      end else if (refreshPend) begin
        strobes = '{loadOut: 1'b1, sel: SEL_CR};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      beat        <= '0;
      refreshPend <= 1'b0;
      greetPend   <= 1'b0;
      greetDone   <= 1'b0;
      linkPrev    <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      linkPrev <= linkUp;
      if (linkRise && !greetDone) begin
        greetPend <= 1'b1;
        greetDone <= 1'b1;
      end
      if (wrFire) begin
        refreshPend <= 1'b1;
      end
      if (advance) begin
        if (active) begin
          outValid <= 1'b1;
          if (beat == BEAT_W'(CHARS)) begin
            active <= 1'b0;
          end else begin
            beat <= beat + 1'b1;
          end
        end else if (greetPend) begin
          outValid  <= 1'b1;
          greetPend <= 1'b0;
        end else if (refreshPend) begin
          outValid    <= 1'b1;
          active      <= 1'b1;
          beat        <= BEAT_W'(1);
          refreshPend <= wrFire;
        end else begin
          outValid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/char_line_buffer.sv
`timescale 1ns/1ps
module char_line_buffer
  import clb_pkg::*;
#(
  parameter  int CHARS  = 8,
  localparam int IDX_W  = $clog2(CHARS),
  localparam int SIZE_W = $clog2(CHARS) + 1,
  localparam int DATA_W = CHARS * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [IDX_W-1:0]  busAddr,
  input  logic [SIZE_W-1:0] busSize,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              linkUp,
  output logic              outValid,
  output logic [7:0]        outData,
  input  logic              outReady
);
  strobes_t         strobes;
  logic             wrFire;
  logic [IDX_W-1:0] charIdx;

  clb_datapath #(.CHARS(CHARS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .strobes   (strobes),
    .charIdx   (charIdx),
    .wrFire    (wrFire),
    .outData   (outData)
  );

  clb_control #(.CHARS(CHARS)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrFire   (wrFire),
    .linkUp   (linkUp),
    .outReady (outReady),
    .outValid (outValid),
    .strobes  (strobes),
    .charIdx  (charIdx)
  );
endmodule

// File: rtl/clb_checker.sv
`timescale 1ns/1ps
module clb_checker #(
  parameter  int CHARS  = 8,
  localparam int SIZE_W = $clog2(CHARS) + 1,
  localparam int DATA_W = CHARS * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busValid,
  input logic              busWrite,
  input logic [SIZE_W-1:0] busSize,
  input logic [DATA_W-1:0] busRdData,
  input logic              outValid,
  input logic [7:0]        outData,
  input logic              outReady
);
  logic isRead;
  logic legal;
  assign isRead = busValid && !busWrite;
  assign legal  = (busSize == SIZE_W'(1)) || (busSize == SIZE_W'(2))
               || (busSize == SIZE_W'(4)) || (busSize == SIZE_W'(8));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outData));

  // R9
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> (outData == 8'h0D) || (outData == 8'h20));

  // R6
  no_nul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outData != 8'h00);

  // R4
  bad_size_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isRead && !legal |-> busRdData == '0);

  // R3
  byte_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isRead && busSize == SIZE_W'(1) |-> busRdData[DATA_W-1:8] == '0);

  // R3
  half_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isRead && busSize == SIZE_W'(4) |-> busRdData[DATA_W-1:32] == '0);

  // R3
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busValid |-> busRdData == '0);
endmodule

bind char_line_buffer clb_checker #(.CHARS(CHARS)) chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busSize   (busSize),
  .busRdData (busRdData),
  .outValid  (outValid),
  .outData   (outData),
  .outReady  (outReady)
);

// File: tb/char_line_buffer_test.sv
`timescale 1ns/1ps
module char_line_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        busValid, busWrite;
  logic [2:0]  busAddr;
  logic [3:0]  busSize;
  logic [63:0] busWrData, busRdData;
  logic        linkUp, outValid, outReady;
  logic [7:0]  outData;

  always #10 clk = ~clk;

  char_line_buffer uut (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWrData(busWrData),
    .busRdData(busRdData), .linkUp(linkUp), .outValid(outValid),
    .outData(outData), .outReady(outReady)
  );

  typedef struct packed {
    logic [2:0]  wa;
    logic [3:0]  ws;
    logic [63:0] wd;
    logic [2:0]  ra;
    logic [3:0]  rs;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{wa: 3'd6, ws: 4'd4, wd: 64'hDEAD_BEEF_4443_4241, ra: 3'd4, rs: 4'd8},
    '{wa: 3'd1, ws: 4'd8, wd: 64'h6867_6665_6463_6261, ra: 3'd0, rs: 4'd8},
    '{wa: 3'd7, ws: 4'd2, wd: 64'hFFFF_FFFF_FFFF_3A39, ra: 3'd6, rs: 4'd4},
    '{wa: 3'd3, ws: 4'd1, wd: 64'h0123_4567_89AB_CD00, ra: 3'd2, rs: 4'd2},
    '{wa: 3'd5, ws: 4'd4, wd: 64'h7777_7777_5A59_5857, ra: 3'd5, rs: 4'd4},
    '{wa: 3'd0, ws: 4'd2, wd: 64'h1111_2222_3333_7170, ra: 3'd7, rs: 4'd1}
  };

  logic [7:0] mdl [8];
  logic [7:0] rx [512];
  int rxCount = 0;
  int nChecks = 0;
  int nBad = 0;

  // Stream monitor: samples mid-cycle, the values the next rising edge sees.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && outValid === 1'b1 && outReady === 1'b1) begin
      if (rxCount < 512) rx[rxCount] = outData;
      rxCount++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL R5 watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legalSize(input logic [3:0] s);
    return (s == 4'd1) || (s == 4'd2) || (s == 4'd4) || (s == 4'd8);
  endfunction

  task automatic doWrite(input logic [2:0] a, input logic [3:0] s,
                         input logic [63:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busSize = s; busWrData = d;
    tick();
    busValid = 1'b0; busWrite = 1'b0;
    if (legalSize(s)) begin
      for (int k = 0; k < 8; k++)
        if (k < int'(s)) mdl[(int'(a) + k) % 8] = d[8*k +: 8];
    end
  endtask

  task automatic readCheck(input logic [2:0] a, input logic [3:0] s,
                           input string tag);
    logic [63:0] exp;
    exp = '0;
    if (legalSize(s)) begin
      for (int k = 0; k < 8; k++)
        if (k < int'(s)) exp[8*k +: 8] = mdl[(int'(a) + k) % 8];
    end
    busValid = 1'b1; busWrite = 1'b0; busAddr = a; busSize = s;
    @(negedge clk);
    check(busRdData === exp, tag, busRdData, exp);
    tick();
    busValid = 1'b0;
  endtask

  task automatic waitCount(input int target, input int limit);
    for (int i = 0; i < limit && rxCount < target; i++) tick();
  endtask

  task automatic lineCheck(input int base, input string tag);
    bit ok;
    logic [63:0] got, exp;
    ok = (rxCount >= base + 9) && (rx[base] === 8'h0D);
    got = '0;
    exp = '0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = (mdl[i] == 8'h00) ? 8'h20 : mdl[i];
      got[8*i +: 8] = rx[base + 1 + i];
      exp[8*i +: 8] = e;
      if (rx[base + 1 + i] !== e) ok = 1'b0;
    end
    check(ok, tag, got, exp);
  endtask

  initial begin
    int base;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    rst_n = 1'b0; busValid = 1'b0; busWrite = 1'b0; busAddr = '0;
    busSize = '0; busWrData = '0; linkUp = 1'b0; outReady = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: idle output, empty store, nothing sent
    @(negedge clk);
    check(outValid === 1'b0 && rxCount == 0, "R1 idle after reset",
          {63'd0, outValid}, 64'd0);
    readCheck(3'd0, 4'd8, "R1 store cleared");

    // R7: first link rise sends one blank, later rises nothing
    linkUp = 1'b1;
    repeat (10) tick();
    check(rxCount == 1 && rx[0] === 8'h20, "R7 first link blank",
          {56'd0, rx[0]}, 64'h20);
    linkUp = 1'b0;
    repeat (3) tick();
    linkUp = 1'b1;
    repeat (10) tick();
    check(rxCount == 1, "R7 no second blank", rxCount, 64'd1);

    // R2 R3 R5 R6: table of writes, each followed by its repaint and a read
    for (int v = 0; v < NV; v++) begin
      base = rxCount;
      doWrite(VECS[v].wa, VECS[v].ws, VECS[v].wd);
      waitCount(base + 9, 60);
      repeat (3) tick();
      lineCheck(base, "R5 R6 repaint line");
      check(rxCount == base + 9, "R5 nine bytes", rxCount, base + 9);
      readCheck(VECS[v].ra, VECS[v].rs, "R2 R3 wrapped read");
    end

    // R3: narrow read at a wrapping offset
    readCheck(3'd7, 4'd2, "R3 wrap read two bytes");

    // R4: illegal sizes
    base = rxCount;
    doWrite(3'd2, 4'd3, 64'h5555_5555_5555_5555);
    doWrite(3'd0, 4'd0, 64'h6666_6666_6666_6666);
    repeat (20) tick();
    check(rxCount == base, "R4 no repaint", rxCount, base);
    readCheck(3'd0, 4'd8, "R4 store unchanged");
    readCheck(3'd0, 4'd6, "R4 illegal read zero");

    // R8 R9: writes during a stalled repaint
    outReady = 1'b0;
    base = rxCount;
    doWrite(3'd0, 4'd1, 64'h41);
    tick(); tick();
    @(negedge clk);
    check(outValid === 1'b1 && outData === 8'h0D, "R9 offered CR",
          {55'd0, outValid, outData}, {55'd0, 1'b1, 8'h0D});
    tick();
    doWrite(3'd3, 4'd2, 64'h4E4D);
    doWrite(3'd7, 4'd1, 64'h5A);
    repeat (3) tick();
    @(negedge clk);
    check(outValid === 1'b1 && outData === 8'h0D && rxCount == base,
          "R9 held while stalled", {55'd0, outValid, outData},
          {55'd0, 1'b1, 8'h0D});
    tick();
    outReady = 1'b1;
    waitCount(base + 18, 80);
    repeat (30) tick();
    check(rxCount == base + 18, "R8 exactly one extra repaint", rxCount,
          base + 18);
    lineCheck(base, "R8 first line");
    lineCheck(base + 9, "R8 second line");
    readCheck(3'd6, 4'd4, "R2 after stall");

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule